// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two signed two's complement operands of `OP_W` bits, with a default of 5, and gives a signed product of `2*OP_W` bits. It does one recoding step per clock. Both operands arrive on a single shared operand input, each under its own load strobe. The multiplicand goes into a holding register. The multiplier goes into the low half of a double-width product register, and the upper half of that register starts at zero. A single-bit history flop sits to the right of the product register.

On each step, the least significant product bit and the history bit select one of three actions on the upper half: subtract the multiplicand, add it, or do nothing. The whole register, together with its history bit, then shifts right arithmetically by one place. The adder keeps one guard bit above the upper half, so that the most negative multiplicand is handled correctly.

A start strobe begins exactly `OP_W` steps. A single-cycle completion pulse follows them. The product stays on `product_o` until the next clear or multiplier load.

Top module: `booth_seq_mul`

## Requirements
- R1: After reset, and after `clr_i` while idle, `product_o` is zero and neither `busy_o` nor `done_o` is high.
- R2: While idle, `ld_mplier_i` puts `operand_i` in `product_o[OP_W-1:0]` and zero in `product_o[2*OP_W-1:OP_W]` on the next edge, and `ld_mcand_i` stores `operand_i` as the multiplicand.
- R3: When `clr_i` and `ld_mplier_i` are high in the same idle cycle, the clear wins and `product_o` becomes zero.
- R4: `start_i` while idle raises `busy_o` for exactly `OP_W` cycles. `done_o` is then high for one cycle with `busy_o` low, and the block returns to idle.
- R5: In each step, the pair {product bit 0, history bit} selects the action on the upper half: 2'b10 subtracts the multiplicand, 2'b01 adds it, and 2'b00 or 2'b11 leaves it unchanged. The register then shifts right arithmetically, with bit 0 moving into the history bit. For multiplicand 3 and multiplier 1 at OP_W=5, `product_o` is 10'h3D0 after the first step and 10'h018 after the second.
- R6: In the `done_o` cycle, `product_o` read as signed equals the signed product of the operands, for example +8 times −12 giving −96.
- R7: A multiplicand of −2^(OP_W−1) gives the correct product, for example −16 × −16 = 256 and −16 × 15 = −240.
- R8: `clr_i`, `ld_mcand_i`, `ld_mplier_i` and `start_i` have no effect while `busy_o` or `done_o` is high.
- R9: After `done_o`, `product_o` holds the product until a clear or multiplier load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_i | input | 1 | Clear product register and history bit |
| ld_mcand_i | input | 1 | Load multiplicand from operand_i |
| ld_mplier_i | input | 1 | Load multiplier into low half of product |
| start_i | input | 1 | Begin the step sequence |
| operand_i | input | OP_W | Shared operand value |
| busy_o | output | 1 | Steps in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 2*OP_W | Product register contents |

## Verification
The bench first runs a vector table that mixes signs and includes zeros, ones and the extremes of the range. A design that sign-extended wrongly, or shifted logically, would give wrong negative products. The most negative multiplicand is tested in both operand positions. If the guard bit were left out, the subtraction would overflow and a large positive value would come out negative. The subtract and add steps are also checked one cycle apart, so that a design with the two actions swapped fails. Further tests assert loads and clears during a run, clear against load in the same cycle, and the cycle count up to the pulse. These catch an extra or a missing step, a product corrupted in mid-run, and a load that overrides a clear.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_ADD = 2'd1,
        OP_SUB = 2'd2
    } op_e;

endpackage

// File: rtl/booth_pair_decode.sv
module booth_pair_decode
    import booth_pkg::*;
(
    input  logic lsb_i,
    input  logic hist_i,
    output op_e  op_o
);
    always_comb begin
        case ({lsb_i, hist_i})
            2'b01:   op_o = OP_ADD;
            2'b10:   op_o = OP_SUB;
            default: op_o = OP_NOP;
        endcase
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int OP_W = 5
) (
    input  logic [OP_W:0]   hi_i,
    input  logic [OP_W-1:0] mcand_i,
    input  op_e             op_i,
    output logic [OP_W:0]   sum_o
);
    logic [OP_W:0] mcand_ext;

    assign mcand_ext = {mcand_i[OP_W-1], mcand_i};

    always_comb begin
        case (op_i)
            OP_ADD:  sum_o = hi_i + mcand_ext;
            OP_SUB:  sum_o = hi_i - mcand_ext;
            default: sum_o = hi_i;
        endcase
    end
endmodule

// File: rtl/booth_step_shift.sv
module booth_step_shift #(
    parameter int OP_W = 5
) (
    input  logic [OP_W:0]     sum_i,
    input  logic [OP_W-1:0]   lo_i,
    output logic [2*OP_W-1:0] prod_o,
    output logic              hist_o
);
    // Guarded sum lands one place lower; its guard bit becomes the new sign.
    assign prod_o = {sum_i, lo_i[OP_W-1:1]};
    assign hist_o = lo_i[0];
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
    import booth_pkg::*;
#(
    parameter int OP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              ld_mcand_i,
    input  logic              ld_mplier_i,
    input  logic              start_i,
    input  logic [OP_W-1:0]   operand_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [2*OP_W-1:0] product_o
);
    localparam int PROD_W = 2 * OP_W;
    localparam int CNT_W  = $clog2(OP_W + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(OP_W - 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  step;
        logic [OP_W-1:0]   mcand;
        logic [PROD_W-1:0] prod;
        logic              hist;
    } state_t;

    state_t st_d, st_q;

    op_e               op_sel;
    logic [OP_W:0]     hi_ext;
    logic [OP_W:0]     sum_w;
    logic [PROD_W-1:0] prod_step;
    logic              hist_step;

    assign hi_ext = {st_q.prod[PROD_W-1], st_q.prod[PROD_W-1:OP_W]};

    booth_pair_decode i_decode (
        .lsb_i  (st_q.prod[0]),
        .hist_i (st_q.hist),
        .op_o   (op_sel)
    );

    booth_addsub #(.OP_W(OP_W)) i_addsub (
        .hi_i    (hi_ext),
        .mcand_i (st_q.mcand),
        .op_i    (op_sel),
        .sum_o   (sum_w)
    );

    booth_step_shift #(.OP_W(OP_W)) i_shift (
        .sum_i  (sum_w),
        .lo_i   (st_q.prod[OP_W-1:0]),
        .prod_o (prod_step),
        .hist_o (hist_step)
    );

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (clr_i) begin
                    st_d.prod = '0;
                    st_d.hist = 1'b0;
                end else if (ld_mplier_i) begin
                    st_d.prod = {{OP_W{1'b0}}, operand_i};
                    st_d.hist = 1'b0;
                end
                if (ld_mcand_i) begin
                    st_d.mcand = operand_i;
                end
                if (start_i) begin
                    st_d.phase = PH_RUN;
                    st_d.step  = '0;
                end
            end
            PH_RUN: begin
                st_d.prod = prod_step;
                st_d.hist = hist_step;
                st_d.step = st_q.step + 1'b1;
                if (st_q.step == LAST_STEP) begin
                    st_d.phase = PH_DONE;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, step: '0, mcand: '0, prod: '0, hist: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = (st_q.phase == PH_RUN);
    assign done_o    = (st_q.phase == PH_DONE);
    assign product_o = st_q.prod;

endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
    parameter int OP_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_i,
    input logic              ld_mplier_i,
    input logic              start_i,
    input logic [OP_W-1:0]   operand_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [2*OP_W-1:0] product_o
);
    localparam int LEN_W = $clog2(OP_W + 2) + 1;

    logic [LEN_W-1:0] run_len;
    logic             idle;

    assign idle = !busy_o && !done_o;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy_o) begin
            run_len <= run_len + 1'b1;
        end else if (!done_o) begin
            run_len <= '0;
        end
    end

    // R1 and R3: a clear while idle wins
    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && idle) |=> (product_o == '0));

    assert_mplier_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_mplier_i && !clr_i && idle) |=>
        (product_o == {{OP_W{1'b0}}, $past(operand_i)}));

    assert_start_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && idle) |=> busy_o);

    assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    assert_step_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (run_len == LEN_W'(OP_W)));

    assert_hold_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> $stable(product_o));

endmodule

bind booth_seq_mul booth_seq_mul_chk #(.OP_W(OP_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .ld_mplier_i (ld_mplier_i),
    .start_i     (start_i),
    .operand_i   (operand_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .product_o   (product_o)
);

// File: tb/test_booth_seq_mul.sv
`timescale 1ns/1ps
module test_booth_seq_mul;
    localparam int OP_W = 5;
    localparam int PW   = 2 * OP_W;
    localparam int NVEC = 12;
    // multiplicand, multiplier, expected product
    localparam int VEC [NVEC][3] = '{
        '{  8, -12, -96}, '{  0,   0,    0}, '{  1,   1,    1},
        '{ -1,  -1,   1}, '{ 15,  15,  225}, '{-16, -16,  256},
        '{-16,  15, -240}, '{ 15, -16, -240}, '{  7,  -3,  -21},
        '{ -5,   6,  -30}, '{  3,   0,    0}, '{-16,   1,  -16}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr_i = 1'b0;
    logic          ld_mcand_i = 1'b0;
    logic          ld_mplier_i = 1'b0;
    logic          start_i = 1'b0;
    logic [OP_W-1:0] operand_i = '0;
    logic          busy_o, done_o;
    logic [PW-1:0] product_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    booth_seq_mul #(.OP_W(OP_W)) i_booth_seq_mul (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .ld_mcand_i(ld_mcand_i),
        .ld_mplier_i(ld_mplier_i), .start_i(start_i), .operand_i(operand_i),
        .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic strobe_load(input int md, input int mr);
        @(negedge clk);
        ld_mcand_i = 1'b1; operand_i = OP_W'(md);
        @(negedge clk);
        ld_mcand_i = 1'b0; ld_mplier_i = 1'b1; operand_i = OP_W'(mr);
        @(negedge clk);
        ld_mplier_i = 1'b0;
    endtask

    // start at the current negedge; returns at the negedge where done_o is high
    task automatic run_and_wait(input string req, input int exp, input bit poke);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R4 busy after start", int'(busy_o), 1);
        if (poke) begin
            clr_i = 1'b1; ld_mcand_i = 1'b1; ld_mplier_i = 1'b1; start_i = 1'b1;
            operand_i = 5'b01010;
        end
        repeat (OP_W) @(negedge clk);
        if (poke) begin
            check("R8 input during done", int'(done_o), 1);
            @(negedge clk);
            clr_i = 1'b0; ld_mcand_i = 1'b0; ld_mplier_i = 1'b0; start_i = 1'b0;
            check(req, int'($signed(product_o)), exp);
        end else begin
            check("R4 done pulse", int'(done_o), 1);
            check(req, int'($signed(product_o)), exp);
            @(negedge clk);
            check("R4 done single", int'(done_o) + int'(busy_o), 0);
            check("R9 product held", int'($signed(product_o)), exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset product", int'(product_o), 0);
        check("R1 reset flags", int'(busy_o) + int'(done_o), 0);

        for (int i = 0; i < NVEC; i++) begin
            strobe_load(VEC[i][0], VEC[i][1]);
            run_and_wait((VEC[i][0] == -16 || VEC[i][1] == -16) ? "R7 extreme" : "R6 product",
                         VEC[i][2], 1'b0);
        end

        // R2: multiplier load visible
        strobe_load(4, -7);
        check("R2 mplier in low half", int'(product_o), 25);

        // R3: clear beats load
        @(negedge clk);
        clr_i = 1'b1; ld_mplier_i = 1'b1; operand_i = 5'd9;
        @(negedge clk);
        clr_i = 1'b0; ld_mplier_i = 1'b0;
        check("R3 clear priority", int'(product_o), 0);

        // R1: clear while idle
        strobe_load(2, 3);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        check("R1 clear", int'(product_o), 0);

        // R5: step-by-step, mcand 3, mplier 1
        strobe_load(3, 1);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        check("R5 subtract step", int'(product_o), 'h3D0);
        @(negedge clk);
        check("R5 add step", int'(product_o), 'h018);
        repeat (OP_W - 2) @(negedge clk);
        check("R5 final", int'($signed(product_o)), 3);
        @(negedge clk);

        // R8: controls ignored while running and in the pulse cycle
        strobe_load(-6, 5);
        run_and_wait("R8 ignored during run", -30, 1'b1);
        check("R8 no restart", int'(busy_o), 0);

        @(negedge clk);
        summary();
    end
endmodule